// File: doc/BRIEF.md
# PCI Host Bridge Control Register File

This block is the processor-side register file of a PCI host bridge. It answers single 32-bit accesses on a simple request/acknowledge processor bus. The low 256 bytes of its offset space hold the bridge's own configuration header as sixty-four 32-bit words. A handful of control registers sit above that window: a configuration address register, a memory base register, an I/O base register and a configuration data port.

Accesses to the data port are forwarded over a level request/acknowledge configuration port to the PCI-side engine, using the address held in the address register. The processor acknowledge is held back until that engine answers. When a write to the I/O base register really changes the decoded base, the block raises a one-cycle relocation pulse and presents the new window base, so that an external decoder can move its 256 KB I/O window.

Device interrupt events are steered to one of the interrupt lines by device number. The device number is the devfn value shifted right by three.

Top module: `pcib_regfile`

## Requirements
- R1: An access acts only when `bus_size` is 2'b10 (32-bit) and `bus_addr[1:0]` is 0. Any other access writes nothing, raises no configuration request and is acknowledged with read data 0.
- R2: Offsets 0x000 to 0x0FC address the 64-word local configuration window. A read returns the last 32-bit word written there, with byte 0 in bits [7:0].
- R3: After reset the header word at offset 0x004 reads 0x02900080. Command is in [15:0] (wait-cycle bit 7). Status is in [31:16] (capability list 0x0010, fast back-to-back 0x0080, medium select timing 0x0200). Other window words are undefined until written. Word 0x004 is writable.
- R4: Offset 0x1C0 is a read/write configuration address register that resets to 0.
- R5: Offset 0x1C4 is the memory base register. It resets to 0, and a write stores the data ANDed with 0xFF000001.
- R6: Offset 0x1C8 is the I/O base register and resets to 0xFE240000. A write whose bits [31:18] equal the stored bits [31:18] changes nothing, including bit 0. Otherwise it stores the data ANDed with 0xFFFC0001, `io_move` is high for exactly the following cycle, and `io_win_base` shows the stored bits [31:18] with zeros below.
- R7: A write to offset 0x220 raises `cfg_req` with `cfg_we`=1, `cfg_addr` equal to the address register and `cfg_wdata` equal to the bus data. The request is held steady until `cfg_ack` is sampled high.
- R8: A read of offset 0x220 raises `cfg_req` with `cfg_we`=0. It is acknowledged with the `cfg_rdata` value sampled alongside `cfg_ack`.
- R9: Offsets in the 12-bit space that are not decoded read as 0, and writes to them change no register.
- R10: Suppose a request is accepted at edge N. A local access raises `bus_ack` at edge N+1. A data port access raises it at the edge after the one that samples `cfg_ack`. `bus_ack` lasts one cycle, and `bus_rdata` is 0 whenever `bus_ack` is low and on write acknowledges.
- R11: An interrupt event sets line `irq_out[irq_devfn[7:3]]` to `irq_level` at the next edge. Other lines are left unchanged, and all lines reset low.
- R12: An interrupt event whose device number `irq_devfn[7:3]` is 4 or more leaves every interrupt line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size, 2'b10 = 32-bit |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle completion |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| cfg_req | output | 1 | Configuration request, held until acknowledged |
| cfg_we | output | 1 | Configuration write flag |
| cfg_addr | output | 32 | Configuration address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Configuration completion |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_ack |
| io_move | output | 1 | Pulse on a real I/O base change |
| io_win_base | output | 32 | Current I/O window base |
| irq_evt | input | 1 | Interrupt level change event |
| irq_devfn | input | 8 | Device/function of the event source |
| irq_level | input | 1 | New interrupt level |
| irq_out | output | 4 | Interrupt lines |

## Verification
The I/O base register is written with three patterns: one matching the stored decoded bits while carrying different low bits, one with new decoded bits and stray low bits, and one that repeats the decoded bits while clearing bit 0. Together they separate a compare on the decoded bits from a compare on the whole word, and a masked store from a raw one. The data port is driven with target latencies of zero and several cycles, and its write and read directions are tried in turn. This shows that the acknowledge tracks the target and is not a fixed delay, and that the request fields are held. Access legality is probed with byte, halfword and misaligned word accesses against both the local window and the data port, to show that an illegal access writes nothing and forwards nothing. Interrupt events use in-range, multi-function and out-of-range device numbers.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  localparam logic [1:0]  SZ_WORD      = 2'b10;
  localparam logic [31:0] OFF_CFGADDR  = 32'h0000_01C0;
  localparam logic [31:0] OFF_MBASE    = 32'h0000_01C4;
  localparam logic [31:0] OFF_IOBASE   = 32'h0000_01C8;
  localparam logic [31:0] OFF_DATA     = 32'h0000_0220;
  localparam logic [31:0] MBASE_MASK   = 32'hFF00_0001;
  localparam logic [31:0] IOBASE_MASK  = 32'hFFFC_0001;
  localparam logic [31:0] IOBASE_RST   = 32'hFE24_0000;
  localparam logic [31:0] HDR_RST      = 32'h0290_0080;
  localparam int          HDR_IDX      = 1;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_WIN, TGT_CFGADDR, TGT_MBASE, TGT_IOBASE, TGT_DATA
  } tgt_e;
endpackage

// File: rtl/pcib_cfg_space.sv
module pcib_cfg_space #(
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  import pcib_pkg::*;

  logic [31:0] mem [WORDS];
  logic [31:0] ram_q;
  logic [31:0] hdr_q;
  logic        hdr_sel_q;
  logic        is_hdr;

  assign is_hdr = (int'(idx) == HDR_IDX);

  // plain single-port RAM, read-first, no reset: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en && !is_hdr) mem[idx] <= wdata;
    ram_q <= mem[idx];
  end

  // header word kept in flops so it has a reset value
  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q     <= HDR_RST;
      hdr_sel_q <= 1'b0;
    end else begin
      if (wr_en && is_hdr) hdr_q <= wdata;
      hdr_sel_q <= is_hdr;
    end
  end

  assign rdata = hdr_sel_q ? hdr_q : ram_q;
endmodule

// File: rtl/pcib_ctrl_regs.sv
module pcib_ctrl_regs (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_cfgaddr,
  input  logic        wr_mbase,
  input  logic        wr_iobase,
  input  logic [31:0] wdata,
  output logic [31:0] cfgaddr_q,
  output logic [31:0] mbase_q,
  output logic [31:0] iobase_q,
  output logic        io_move,
  output logic [31:0] io_win_base
);
  import pcib_pkg::*;

  logic base_differs;
  assign base_differs = (wdata[31:18] != iobase_q[31:18]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgaddr_q <= '0;
      mbase_q   <= '0;
      iobase_q  <= IOBASE_RST;
      io_move   <= 1'b0;
    end else begin
      io_move <= 1'b0;
      if (wr_cfgaddr) cfgaddr_q <= wdata;
      if (wr_mbase)   mbase_q   <= wdata & MBASE_MASK;
      if (wr_iobase && base_differs) begin
        iobase_q <= wdata & IOBASE_MASK;
        io_move  <= 1'b1;
      end
    end
  end

  assign io_win_base = {iobase_q[31:18], 18'b0};
endmodule

// File: rtl/pcib_cfg_port.sv
module pcib_cfg_port (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        start_we,
  input  logic [31:0] start_addr,
  input  logic [31:0] start_wdata,
  output logic        cfg_req,
  output logic        cfg_we,
  output logic [31:0] cfg_addr,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_ack,
  input  logic [31:0] cfg_rdata,
  output logic        done,
  output logic [31:0] done_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_req    <= 1'b0;
      cfg_we     <= 1'b0;
      cfg_addr   <= '0;
      cfg_wdata  <= '0;
      done       <= 1'b0;
      done_rdata <= '0;
    end else begin
      done <= 1'b0;
      if (cfg_req) begin
        if (cfg_ack) begin
          cfg_req    <= 1'b0;
          done       <= 1'b1;
          done_rdata <= cfg_we ? 32'h0 : cfg_rdata;
        end
      end else if (start) begin
        cfg_req   <= 1'b1;
        cfg_we    <= start_we;
        cfg_addr  <= start_addr;
        cfg_wdata <= start_wdata;
      end
    end
  end
endmodule

// File: rtl/pcib_irq_route.sv
module pcib_irq_route #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt,
  input  logic [7:0]         devfn,
  input  logic               level,
  output logic [NUM_IRQ-1:0] lines
);
  logic [4:0] dev;
  logic       unused_fn;
  assign dev       = devfn[7:3];
  assign unused_fn = ^devfn[2:0];

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)                            lines[i] <= 1'b0;
      else if (evt && int'(dev) == i)     lines[i] <= level;
    end
  end
endmodule

// File: rtl/pcib_regfile.sv
module pcib_regfile #(
  parameter int ADDR_W    = 12,
  parameter int CFG_WORDS = 64,
  parameter int NUM_IRQ   = 4,
  localparam int IDX_W    = $clog2(CFG_WORDS),
  localparam int WIN_BYTES = CFG_WORDS * 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [1:0]         bus_size,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic               bus_ack,
  output logic [31:0]        bus_rdata,
  output logic               cfg_req,
  output logic               cfg_we,
  output logic [31:0]        cfg_addr,
  output logic [31:0]        cfg_wdata,
  input  logic               cfg_ack,
  input  logic [31:0]        cfg_rdata,
  output logic               io_move,
  output logic [31:0]        io_win_base,
  input  logic               irq_evt,
  input  logic [7:0]         irq_devfn,
  input  logic               irq_level,
  output logic [NUM_IRQ-1:0] irq_out
);
  import pcib_pkg::*;

  logic [31:0] a32;
  logic        legal;
  tgt_e        tgt;
  logic        rsp_pend, rsp_we;
  tgt_e        rsp_tgt;
  logic [31:0] win_rdata, cfgaddr_q, mbase_q, iobase_q;
  logic        port_done;
  logic [31:0] port_rdata;
  logic [31:0] local_rdata;

  // decode
  always_comb begin
    a32 = '0;
    a32[ADDR_W-1:0] = bus_addr;
    legal = (bus_size == SZ_WORD) && (bus_addr[1:0] == 2'b00);
    if (!legal)                          tgt = TGT_NONE;
    else if (a32 < 32'(WIN_BYTES))       tgt = TGT_WIN;
    else if (a32 == OFF_CFGADDR)         tgt = TGT_CFGADDR;
    else if (a32 == OFF_MBASE)           tgt = TGT_MBASE;
    else if (a32 == OFF_IOBASE)          tgt = TGT_IOBASE;
    else if (a32 == OFF_DATA)            tgt = TGT_DATA;
    else                                 tgt = TGT_NONE;
  end

  pcib_cfg_space #(.WORDS(CFG_WORDS)) u_space (
    .clk   (clk),
    .rst   (rst),
    .wr_en (bus_req && bus_we && tgt == TGT_WIN),
    .idx   (bus_addr[IDX_W+1:2]),
    .wdata (bus_wdata),
    .rdata (win_rdata)
  );

  pcib_ctrl_regs u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_cfgaddr  (bus_req && bus_we && tgt == TGT_CFGADDR),
    .wr_mbase    (bus_req && bus_we && tgt == TGT_MBASE),
    .wr_iobase   (bus_req && bus_we && tgt == TGT_IOBASE),
    .wdata       (bus_wdata),
    .cfgaddr_q   (cfgaddr_q),
    .mbase_q     (mbase_q),
    .iobase_q    (iobase_q),
    .io_move     (io_move),
    .io_win_base (io_win_base)
  );

  pcib_cfg_port u_port (
    .clk         (clk),
    .rst         (rst),
    .start       (bus_req && tgt == TGT_DATA),
    .start_we    (bus_we),
    .start_addr  (cfgaddr_q),
    .start_wdata (bus_wdata),
    .cfg_req     (cfg_req),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cfg_ack     (cfg_ack),
    .cfg_rdata   (cfg_rdata),
    .done        (port_done),
    .done_rdata  (port_rdata)
  );

  pcib_irq_route #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .evt   (irq_evt),
    .devfn (irq_devfn),
    .level (irq_level),
    .lines (irq_out)
  );

  // response stage for local targets
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_pend <= 1'b0;
      rsp_we   <= 1'b0;
      rsp_tgt  <= TGT_NONE;
    end else begin
      rsp_pend <= bus_req && (tgt != TGT_DATA);
      rsp_we   <= bus_we;
      rsp_tgt  <= tgt;
    end
  end

  always_comb begin
    case (rsp_tgt)
      TGT_WIN:     local_rdata = win_rdata;
      TGT_CFGADDR: local_rdata = cfgaddr_q;
      TGT_MBASE:   local_rdata = mbase_q;
      TGT_IOBASE:  local_rdata = iobase_q;
      default:     local_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= rsp_pend || port_done;
      if (rsp_pend)       bus_rdata <= rsp_we ? 32'h0 : local_rdata;
      else if (port_done) bus_rdata <= port_rdata;
      else                bus_rdata <= 32'h0;
    end
  end
endmodule

// File: rtl/pcib_regfile_chk.sv
module pcib_regfile_chk #(
  parameter int NUM_IRQ = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_ack,
  input logic [31:0]        bus_rdata,
  input logic               cfg_req,
  input logic               cfg_ack,
  input logic               cfg_we,
  input logic [31:0]        cfg_addr,
  input logic [31:0]        cfg_wdata,
  input logic               io_move,
  input logic [31:0]        io_win_base,
  input logic [31:0]        mbase_q,
  input logic               irq_evt,
  input logic [7:0]         irq_devfn,
  input logic [NUM_IRQ-1:0] irq_out
);
  a_r5_mbase_mask: assert property (@(posedge clk) disable iff (rst)
    (mbase_q & ~32'hFF00_0001) == 32'h0);

  a_r6_move_changes_base: assert property (@(posedge clk) disable iff (rst)
    io_move |-> (io_win_base != $past(io_win_base)));

  a_r6_base_needs_move: assert property (@(posedge clk) disable iff (rst)
    (io_win_base != $past(io_win_base)) |-> io_move);

  a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_we)
                               && $stable(cfg_wdata)));

  a_r10_ack_single: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_ack |-> (bus_rdata == 32'h0));

  a_r12_irq_range: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_evt) && (int'($past(irq_devfn[7:3])) >= NUM_IRQ)) |-> $stable(irq_out));
endmodule

bind pcib_regfile pcib_regfile_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_ack     (bus_ack),
  .bus_rdata   (bus_rdata),
  .cfg_req     (cfg_req),
  .cfg_ack     (cfg_ack),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .io_move     (io_move),
  .io_win_base (io_win_base),
  .mbase_q     (mbase_q),
  .irq_evt     (irq_evt),
  .irq_devfn   (irq_devfn),
  .irq_out     (irq_out)
);

// File: tb/sim_pcib_regfile.sv
module sim_pcib_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_size = 2'b10;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic        cfg_req, cfg_we;
  logic [31:0] cfg_addr, cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic        io_move;
  logic [31:0] io_win_base;
  logic        irq_evt = 1'b0, irq_level = 1'b0;
  logic [7:0]  irq_devfn = '0;
  logic [3:0]  irq_out;

  int n_chk = 0, n_bad = 0;
  int move_cnt = 0;
  int tgt_delay = 0, tgt_cnt = 0, tgt_reqs = 0;
  logic        tgt_we;
  logic [31:0] tgt_addr, tgt_data;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcib_regfile u0 (.*);

  always @(posedge clk) if (!rst && io_move) move_cnt++;

  // PCI-side configuration target model
  always @(negedge clk) begin
    if (cfg_ack) cfg_ack <= 1'b0;
    else if (cfg_req) begin
      if (tgt_cnt == tgt_delay) begin
        tgt_cnt   = 0;
        tgt_reqs++;
        tgt_we    = cfg_we;
        tgt_addr  = cfg_addr;
        tgt_data  = cfg_wdata;
        cfg_rdata <= cfg_addr ^ 32'h5A5A_0000;
        cfg_ack   <= 1'b1;
      end else tgt_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [1:0] sz, input logic [11:0] a,
                     input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_req = 1'b0;
    waits = 0;
    rd = 32'hXXXX_XXXX;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      waits++;
      if (bus_ack) begin rd = bus_rdata; break; end
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; int w;
    acc(1'b1, 2'b10, a, d, r, w);
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] r);
    int w;
    acc(1'b0, 2'b10, a, 32'h0, r, w);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    rd32(12'h004, r); chk("R3 header reset", r, 32'h0290_0080);
    rd32(12'h1C0, r); chk("R4 addr reset", r, 32'h0);
    rd32(12'h1C4, r); chk("R5 mbase reset", r, 32'h0);
    rd32(12'h1C8, r); chk("R6 iobase reset", r, 32'hFE24_0000);
    chk("R6 window reset", io_win_base, 32'hFE24_0000);
    chk("R11 irq reset", {28'h0, irq_out}, 32'h0);
  endtask

  task automatic t_window;
    logic [31:0] r;
    wr(12'h000, 32'h1234_5678);
    wr(12'h0FC, 32'hDEAD_BEEF);
    wr(12'h040, 32'h0000_00A5);
    wr(12'h004, 32'h1111_2222);
    rd32(12'h000, r); chk("R2 word 0", r, 32'h1234_5678);
    rd32(12'h0FC, r); chk("R2 last word", r, 32'hDEAD_BEEF);
    rd32(12'h040, r); chk("R2 mid word", r, 32'h0000_00A5);
    rd32(12'h004, r); chk("R3 header writable", r, 32'h1111_2222);
  endtask

  task automatic t_regs;
    logic [31:0] r;
    wr(12'h1C0, 32'hCAFE_F00D);
    rd32(12'h1C0, r); chk("R4 addr rw", r, 32'hCAFE_F00D);
    wr(12'h1C4, 32'hFFFF_FFFF);
    rd32(12'h1C4, r); chk("R5 mbase mask", r, 32'hFF00_0001);
    wr(12'h1C4, 32'h5A00_FFFE);
    rd32(12'h1C4, r); chk("R5 mbase mask 2", r, 32'h5A00_0000);
  endtask

  task automatic t_iobase;
    logic [31:0] r;
    int m0;
    m0 = move_cnt;
    wr(12'h1C8, 32'hFE27_FFFF);
    rd32(12'h1C8, r); chk("R6 same base ignored", r, 32'hFE24_0000);
    chk("R6 no move pulse", 32'(move_cnt - m0), 32'd0);
    wr(12'h1C8, 32'h1234_5679);
    rd32(12'h1C8, r); chk("R6 masked store", r, 32'h1234_0001);
    chk("R6 one move pulse", 32'(move_cnt - m0), 32'd1);
    chk("R6 window base", io_win_base, 32'h1234_0000);
    wr(12'h1C8, 32'h1234_0000);
    rd32(12'h1C8, r); chk("R6 bit0 kept on equal base", r, 32'h1234_0001);
    chk("R6 still one pulse", 32'(move_cnt - m0), 32'd1);
  endtask

  task automatic t_size;
    logic [31:0] r; int w, q0;
    wr(12'h1C0, 32'h0000_1111);
    acc(1'b1, 2'b00, 12'h1C0, 32'hFFFF_FFFF, r, w);
    acc(1'b1, 2'b01, 12'h1C0, 32'hFFFF_FFFF, r, w);
    rd32(12'h1C0, r); chk("R1 narrow writes ignored", r, 32'h0000_1111);
    acc(1'b0, 2'b01, 12'h1C0, 32'h0, r, w); chk("R1 narrow read zero", r, 32'h0);
    acc(1'b0, 2'b10, 12'h1C2, 32'h0, r, w); chk("R1 misaligned read zero", r, 32'h0);
    acc(1'b0, 2'b00, 12'h004, 32'h0, r, w); chk("R1 byte window read zero", r, 32'h0);
    q0 = tgt_reqs;
    acc(1'b1, 2'b00, 12'h220, 32'h1, r, w);
    acc(1'b0, 2'b11, 12'h220, 32'h0, r, w); chk("R1 narrow port read zero", r, 32'h0);
    chk("R1 no config request", 32'(tgt_reqs - q0), 32'd0);
  endtask

  task automatic t_undecoded;
    logic [31:0] r;
    wr(12'h1CC, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h224, 32'hFFFF_FFFF);
    rd32(12'h100, r); chk("R9 0x100 zero", r, 32'h0);
    rd32(12'h1CC, r); chk("R9 0x1CC zero", r, 32'h0);
    rd32(12'h224, r); chk("R9 0x224 zero", r, 32'h0);
    rd32(12'hFFC, r); chk("R9 0xFFC zero", r, 32'h0);
    rd32(12'h1C0, r); chk("R9 addr reg untouched", r, 32'h0000_1111);
    rd32(12'h1C8, r); chk("R9 iobase untouched", r, 32'h1234_0001);
    rd32(12'h000, r); chk("R9 window untouched", r, 32'h1234_5678);
  endtask

  task automatic t_port;
    logic [31:0] r; int w;
    wr(12'h1C0, 32'h8000_1234);
    tgt_delay = 3;
    acc(1'b1, 2'b10, 12'h220, 32'h55AA_55AA, r, w);
    chk("R7 write flag", {31'h0, tgt_we}, 32'd1);
    chk("R7 write addr", tgt_addr, 32'h8000_1234);
    chk("R7 write data", tgt_data, 32'h55AA_55AA);
    chk("R10 port write latency", 32'(w), 32'd5);
    chk("R10 write ack data zero", r, 32'h0);
    tgt_delay = 0;
    acc(1'b0, 2'b10, 12'h220, 32'h0, r, w);
    chk("R8 read flag", {31'h0, tgt_we}, 32'd0);
    chk("R8 read data", r, 32'h8000_1234 ^ 32'h5A5A_0000);
    chk("R10 port read latency d0", 32'(w), 32'd2);
    wr(12'h1C0, 32'h0001_0800);
    tgt_delay = 6;
    acc(1'b0, 2'b10, 12'h220, 32'h0, r, w);
    chk("R8 read data 2", r, 32'h0001_0800 ^ 32'h5A5A_0000);
    chk("R10 port read latency d6", 32'(w), 32'd8);
    acc(1'b0, 2'b10, 12'h1C4, 32'h0, r, w);
    chk("R10 local latency", 32'(w), 32'd1);
  endtask

  task automatic irq_ev(input logic [7:0] df, input logic lv);
    @(negedge clk);
    irq_evt = 1'b1; irq_devfn = df; irq_level = lv;
    @(negedge clk);
    irq_evt = 1'b0;
  endtask

  task automatic t_irq;
    irq_ev(8'h10, 1'b1); chk("R11 dev2 set", {28'h0, irq_out}, 32'h4);
    irq_ev(8'h0B, 1'b1); chk("R11 dev1 func3 set", {28'h0, irq_out}, 32'h6);
    irq_ev(8'h28, 1'b1); chk("R12 dev5 ignored", {28'h0, irq_out}, 32'h6);
    irq_ev(8'hF8, 1'b0); chk("R12 dev31 ignored", {28'h0, irq_out}, 32'h6);
    irq_ev(8'h10, 1'b0); chk("R11 dev2 clear", {28'h0, irq_out}, 32'h2);
    irq_ev(8'h18, 1'b1); chk("R11 dev3 set", {28'h0, irq_out}, 32'hA);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset;
    t_window;
    t_regs;
    t_iobase;
    t_size;
    t_undecoded;
    t_port;
    t_irq;
    repeat (3) @(negedge clk);
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule